// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block watches the accesses a processor core makes to memory and flags the ones that fall on a programmed breakpoint. It holds four breakpoint address registers, one control word and one status word, all reached through a single-cycle register port. The control word gives each breakpoint a local and a global enable bit, plus a packed 2-bit access-type code and a 2-bit region-length code. The status word collects sticky hit bits that software clears by writing the word.

Every access is offered on a valid/ready stream carrying the address, the access kind and the access size. The block never applies back-pressure: `acc_ready` is always high, so each cycle with `acc_valid` high is one accepted access. One cycle after an accepted access that touches at least one enabled breakpoint region, `bp_hit` pulses high for exactly one cycle. In the same cycle the matching hit bits appear in the status word. A debug-extensions input decides whether the otherwise undefined access-type code selects I/O accesses.

Top module: `bkpt_match_unit`

## Requirements
- R1: After reset all address registers and the control word read 0, the status word reads 32'hFFFF0000, and `bp_hit` is low.
- R2: `reg_sel` selects address register n (0 to 3), the status word (4) or the control word (5). A write with `reg_we` takes effect at the next clock edge. `reg_rdata` shows the selected register in the same cycle. Codes 6 and 7 read as 0, and writes to them change no register.
- R3: Breakpoint n takes part in matching only when control bit 2n (local enable) or bit 2n+1 (global enable) is set.
- R4: Breakpoint n's access-type code sits in control bits [17+4n:16+4n]. Its length code sits in bits [19+4n:18+4n].
- R5: Length code 00 covers the single byte at the address. Code 01 covers the aligned 2-byte pair, ignoring address bit 0. Code 11 covers the aligned 4-byte word, ignoring address bits 1:0. Code 10 never matches.
- R6: `acc_kind` is 00 for fetch, 01 for read, 10 for write and 11 for I/O. Access-type code 00 matches fetches only. Code 01 matches writes only. Code 11 matches reads and writes but not fetches. Code 10 matches I/O accesses when `de_en` is high and nothing otherwise.
- R7: `acc_size` 00, 01 and 11 mean 1, 2 and 4 bytes. A breakpoint hits when any byte of the access lies inside its region.
- R8: `acc_ready` is always high. `bp_hit` is high for exactly the one cycle after an accepted access that hits any enabled breakpoint, and is low at all other times.
- R9: Status bit n (n = 0 to 3) is set in the same cycle as the `bp_hit` pulse caused by breakpoint n. It stays set until software writes the status word. Bits 31:16 always read as 1, bits 15:13 read as last written, and the remaining low bits read 0.
- R10: When a status write and a hit land on the same edge, the new hit bits are ORed into the written value.
- R11: An access in the same cycle as a register write is matched against the register values from before that write.
- R12: Accesses are naturally aligned, and `acc_size` is never 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register value |
| de_en | input | 1 | Debug-extensions enable: access-type code 10 selects I/O |
| acc_valid | input | 1 | Access offered |
| acc_ready | output | 1 | Access accepted (always high) |
| acc_addr | input | ADDR_W | Access byte address |
| acc_kind | input | 2 | Access kind: fetch, read, write, I/O |
| acc_size | input | 2 | Access size code |
| bp_hit | output | 1 | One-cycle breakpoint hit pulse |

## Verification
The assertions assume that every offered access is naturally aligned for its size and never carries size code 10; otherwise the lane-overlap test would give a meaningless result. The bench keeps within this rule by building every access address from an aligned offset stepped by the access size. It then sweeps all base offsets, length codes, access-type codes and extension settings against every legal kind, size and offset, both inside and outside the breakpoint's 4-byte word.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_READ  = 2'b01,
    KIND_WRITE = 2'b10,
    KIND_IO    = 2'b11
  } acc_kind_e;

  localparam logic [2:0] SEL_STATUS = 3'd4;
  localparam logic [2:0] SEL_CTRL   = 3'd5;

  // Field positions inside the control word
  localparam int CTRL_TYPE_LSB = 16;
  localparam int CTRL_LEN_LSB  = 18;
  localparam int CTRL_STRIDE   = 4;

  // Byte lanes of one 4-byte word covered by a span starting at offset
  // off with size/length code; code 10 covers nothing.
  function automatic logic [3:0] lane_mask(input logic [1:0] off,
                                           input logic [1:0] code);
    logic [3:0] m;
    case (code)
      2'b00:   m = 4'b0001 << off;
      2'b01:   m = off[1] ? 4'b1100 : 4'b0011;
      2'b11:   m = 4'b1111;
      default: m = 4'b0000;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/bkpt_slot.sv
module bkpt_slot
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic              en,
  input  logic [1:0]        type_code,
  input  logic [1:0]        len_code,
  input  logic              de_en,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_kind,
  input  logic [1:0]        acc_size,
  output logic              match
);

  logic       word_eq;
  logic       kind_ok;
  logic [3:0] region_lanes;
  logic [3:0] access_lanes;

  assign word_eq      = (base[ADDR_W-1:2] == acc_addr[ADDR_W-1:2]);
  assign region_lanes = lane_mask(base[1:0], len_code);
  assign access_lanes = lane_mask(acc_addr[1:0], acc_size);

  always_comb begin
    case (type_code)
      2'b00:   kind_ok = (acc_kind == KIND_FETCH);
      2'b01:   kind_ok = (acc_kind == KIND_WRITE);
      2'b11:   kind_ok = (acc_kind == KIND_READ) || (acc_kind == KIND_WRITE);
      default: kind_ok = de_en && (acc_kind == KIND_IO);
    endcase
  end

  assign match = en && kind_ok && word_eq && |(region_lanes & access_lanes);

endmodule

// File: rtl/bkpt_status.sv
module bkpt_status #(
  parameter int NUM_BP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [NUM_BP-1:0] wr_bits,
  input  logic [2:0]        wr_flags,
  input  logic              hit_valid,
  input  logic [NUM_BP-1:0] hit_set,
  output logic [31:0]       word
);

  logic [NUM_BP-1:0] bits_q;
  logic [2:0]        flags_q;
  logic [NUM_BP-1:0] hit_new;

  assign hit_new = hit_valid ? hit_set : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bits_q  <= '0;
      flags_q <= '0;
    end else if (wr_en) begin
      bits_q  <= wr_bits | hit_new;
      flags_q <= wr_flags;
    end else begin
      bits_q  <= bits_q | hit_new;
    end
  end

  always_comb begin
    word               = {16'hFFFF, 16'h0000};
    word[15:13]        = flags_q;
    word[NUM_BP-1:0]   = bits_q;
  end

  // Hit bits never drop without a status write
  assert_sticky_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((bits_q & $past(bits_q)) == $past(bits_q)));

  // A status write merges with the hits landing on the same edge
  assert_write_merge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (bits_q == ($past(wr_bits) | $past(hit_new))));

endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32,  // 3 to 32
  parameter int NUM_BP = 4    // 1 to 4, limited by the control word layout
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              de_en,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_kind,
  input  logic [1:0]        acc_size,
  output logic              bp_hit
);

  localparam int SEL_W = 3;

  logic [NUM_BP-1:0][ADDR_W-1:0] base_q;
  logic [31:0]                   ctrl_q;
  logic [NUM_BP-1:0]             slot_match;
  logic [NUM_BP-1:0]             slot_en;
  logic [31:0]                   status_word;
  logic                          acc_fire;
  logic                          hit_q;

  assign acc_ready = 1'b1;
  assign acc_fire  = acc_valid && acc_ready;

  // Control word
  always_ff @(posedge clk) begin
    if (!rst_n)                           ctrl_q <= '0;
    else if (reg_we && reg_sel == SEL_CTRL) ctrl_q <= reg_wdata;
  end

  // Per-breakpoint address register and comparator
  for (genvar i = 0; i < NUM_BP; i++) begin : g_slot
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(i);
    localparam int TYPE_LSB = CTRL_TYPE_LSB + CTRL_STRIDE * i;
    localparam int LEN_LSB  = CTRL_LEN_LSB + CTRL_STRIDE * i;

    always_ff @(posedge clk) begin
      if (!rst_n)                           base_q[i] <= '0;
      else if (reg_we && reg_sel == MY_SEL) base_q[i] <= reg_wdata[ADDR_W-1:0];
    end

    assign slot_en[i] = ctrl_q[2*i] | ctrl_q[2*i+1];

    bkpt_slot #(.ADDR_W(ADDR_W)) u_slot (
      .base      (base_q[i]),
      .en        (slot_en[i]),
      .type_code (ctrl_q[TYPE_LSB +: 2]),
      .len_code  (ctrl_q[LEN_LSB +: 2]),
      .de_en     (de_en),
      .acc_addr  (acc_addr),
      .acc_kind  (acc_kind),
      .acc_size  (acc_size),
      .match     (slot_match[i])
    );

    // Length code 10 never produces a match
    assert_len_undef_R5: assert property (@(posedge clk) disable iff (!rst_n)
      slot_match[i] |-> (ctrl_q[LEN_LSB +: 2] != 2'b10));

    // Only enabled breakpoints match
    assert_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      slot_match[i] |-> (ctrl_q[2*i] || ctrl_q[2*i+1]));

    // Fetch-type breakpoints match fetches only
    assert_fetch_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_match[i] && ctrl_q[TYPE_LSB +: 2] == 2'b00) |-> (acc_kind == 2'b00));
  end

  // Status word
  bkpt_status #(.NUM_BP(NUM_BP)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_we && reg_sel == SEL_STATUS),
    .wr_bits   (reg_wdata[NUM_BP-1:0]),
    .wr_flags  (reg_wdata[15:13]),
    .hit_valid (acc_fire),
    .hit_set   (slot_match),
    .word      (status_word)
  );

  // Hit pulse: one per accepted access
  always_ff @(posedge clk) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= acc_fire && (|slot_match);
  end
  assign bp_hit = hit_q;

  // Register read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_sel == SEL_STATUS)    reg_rdata = status_word;
    else if (reg_sel == SEL_CTRL) reg_rdata = ctrl_q;
    for (int k = 0; k < NUM_BP; k++) begin
      if (reg_sel == SEL_W'(k)) reg_rdata[ADDR_W-1:0] = base_q[k];
    end
  end

  // Offered accesses are aligned and carry a legal size (input rule)
  assert_acc_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (acc_size != 2'b10) &&
                  !(acc_size == 2'b01 && acc_addr[0]) &&
                  !(acc_size == 2'b11 && acc_addr[1:0] != 2'b00));

  // A pulse is only ever the answer to an accepted access
  assert_hit_follows_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bp_hit |-> $past(acc_fire));

  // The pulse and a status hit bit appear together
  assert_status_on_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bp_hit |-> (status_word[NUM_BP-1:0] != '0));

endmodule

// File: tb/sim_bkpt_match_unit.sv
module sim_bkpt_match_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        de_en = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_kind = 2'b00;
  logic [1:0]  acc_size = 2'b00;
  logic        bp_hit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  bkpt_match_unit #(.ADDR_W(32), .NUM_BP(4)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .de_en(de_en),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_addr(acc_addr),
    .acc_kind(acc_kind), .acc_size(acc_size), .bp_hit(bp_hit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  // Offer one access; returns at the negedge where the pulse is visible
  task automatic access(input logic [31:0] a, input logic [1:0] k, input logic [1:0] s);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_kind = k; acc_size = s;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  function automatic int code_bytes(input logic [1:0] c);
    case (c)
      2'b00: return 1;
      2'b01: return 2;
      2'b11: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic bit model_hit(input logic [31:0] base, input logic [1:0] len,
                                   input logic [1:0] typ, input bit de,
                                   input logic [31:0] a, input logic [1:0] k,
                                   input logic [1:0] s);
    int lb, sb;
    longint rs, ra;
    bit kind_ok;
    lb = code_bytes(len);
    sb = code_bytes(s);
    if (lb == 0) return 1'b0;
    rs = longint'(base) - (longint'(base) % lb);
    ra = longint'(a);
    case (typ)
      2'b00: kind_ok = (k == 2'b00);
      2'b01: kind_ok = (k == 2'b10);
      2'b11: kind_ok = (k == 2'b01) || (k == 2'b10);
      default: kind_ok = de && (k == 2'b11);
    endcase
    return kind_ok && (ra < rs + lb) && (rs < ra + sb);
  endfunction

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), d); chk("R1 address reg after reset", d, 32'h0);
    end
    rd(3'd5, d); chk("R1 control after reset", d, 32'h0);
    rd(3'd4, d); chk("R1 status after reset", d, 32'hFFFF0000);
    chk("R1 hit low after reset", {31'b0, bp_hit}, 32'h0);
    chk("R8 ready high", {31'b0, acc_ready}, 32'h1);

    // R2: readback and unused selects
    wr(3'd0, 32'h1111_2220); wr(3'd1, 32'h3333_4444);
    wr(3'd2, 32'h5555_6666); wr(3'd3, 32'h7777_8888);
    wr(3'd6, 32'hDEAD_BEEF); wr(3'd7, 32'hCAFE_F00D);
    rd(3'd0, d); chk("R2 addr0 readback", d, 32'h1111_2220);
    rd(3'd3, d); chk("R2 addr3 readback", d, 32'h7777_8888);
    rd(3'd6, d); chk("R2 select 6 reads zero", d, 32'h0);
    rd(3'd7, d); chk("R2 select 7 reads zero", d, 32'h0);
    rd(3'd1, d); chk("R2 addr1 untouched by select 7 write", d, 32'h3333_4444);
    rd(3'd5, d); chk("R2 control untouched by select 6 write", d, 32'h0);
    wr(3'd5, 32'h00F0_A000);
    rd(3'd5, d); chk("R2 control readback", d, 32'h00F0_A000);
    wr(3'd4, 32'h0000_E00F);
    rd(3'd4, d); chk("R9 status flags and ones", d, 32'hFFFF_E00F);
    wr(3'd4, 32'h0);

    // R5 R6 R7: sweep on breakpoint 0, local enable only
    for (int bo = 0; bo < 4; bo++)
      for (int len = 0; len < 4; len++)
        for (int typ = 0; typ < 4; typ++)
          for (int de = 0; de < 2; de++) begin
            logic [31:0] base;
            base = 32'h0000_1000 | 32'(bo);
            wr(3'd0, base);
            wr(3'd5, 32'h1 | (32'(typ) << 16) | (32'(len) << 18));
            de_en = 1'(de);
            for (int k = 0; k < 4; k++)
              for (int sc = 0; sc < 3; sc++)
                for (int w = 0; w < 2; w++) begin
                  logic [1:0] s;
                  int sb;
                  s = (sc == 0) ? 2'b00 : (sc == 1) ? 2'b01 : 2'b11;
                  sb = code_bytes(s);
                  for (int off = 0; off < 4; off += sb) begin
                    logic [31:0] a;
                    bit exp;
                    a = 32'h0000_1000 + 32'(4 * w) + 32'(off);
                    exp = model_hit(base, 2'(len), 2'(typ), 1'(de), a, 2'(k), s);
                    wr(3'd4, 32'h0);
                    access(a, 2'(k), s);
                    chk("R5 R6 R7 hit pulse", {31'b0, bp_hit}, {31'b0, exp});
                    rd(3'd4, d);
                    chk("R9 status bit0 on hit", d, 32'hFFFF0000 | {31'b0, exp});
                  end
                end
          end
    de_en = 1'b0;

    // R3 R4: four breakpoints, global and local enables, distinct fields
    wr(3'd0, 32'h0000_2000); wr(3'd1, 32'h0000_2010);
    wr(3'd2, 32'h0000_2020); wr(3'd3, 32'h0000_2030);
    // bp0 disabled; bp1 G fetch 1B; bp2 L write 4B; bp3 G rw 2B
    wr(3'd5, 32'h0000_0088 | 32'h0000_0000 | (32'h1 << 24) | (32'h3 << 26)
                | (32'h3 << 28) | (32'h1 << 30) | 32'h10);
    wr(3'd4, 32'h0);
    access(32'h0000_2000, 2'b00, 2'b00);
    chk("R3 disabled breakpoint no pulse", {31'b0, bp_hit}, 32'h0);
    access(32'h0000_2010, 2'b00, 2'b00);
    chk("R3 global enable hits", {31'b0, bp_hit}, 32'h1);
    access(32'h0000_2022, 2'b10, 2'b01);
    chk("R4 bp2 write 4B hits", {31'b0, bp_hit}, 32'h1);
    access(32'h0000_2032, 2'b01, 2'b01);
    chk("R4 bp3 read outside 2B pair", {31'b0, bp_hit}, 32'h0);
    access(32'h0000_2030, 2'b01, 2'b11);
    chk("R4 bp3 read 4B overlaps", {31'b0, bp_hit}, 32'h1);
    rd(3'd4, d); chk("R9 sticky bits of bp1 bp2 bp3", d, 32'hFFFF000E);
    // R8: pulse lasts one cycle
    @(negedge clk);
    chk("R8 pulse ends after one cycle", {31'b0, bp_hit}, 32'h0);

    // R10: status write with simultaneous hit on bp1
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 3'd4; reg_wdata = 32'h0000_0001;
    acc_valid = 1'b1; acc_addr = 32'h0000_2010; acc_kind = 2'b00; acc_size = 2'b00;
    @(negedge clk);
    reg_we = 1'b0; acc_valid = 1'b0;
    rd(3'd4, d); chk("R10 written bits merged with hit", d, 32'hFFFF0003);

    // R11: register write in the access cycle uses the old address
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 3'd1; reg_wdata = 32'h0000_3000;
    acc_valid = 1'b1; acc_addr = 32'h0000_2010; acc_kind = 2'b00; acc_size = 2'b00;
    @(negedge clk);
    reg_we = 1'b0; acc_valid = 1'b0;
    chk("R11 match uses old address", {31'b0, bp_hit}, 32'h1);
    access(32'h0000_2010, 2'b00, 2'b00);
    chk("R11 new address takes over", {31'b0, bp_hit}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule